// File: doc/BRIEF.md
# DDR2 Command Bus Decoder and Power-State Monitor

This block watches a DDR2 SDRAM command bus and names the command that the controller presents on every rising clock edge. It keeps the clock-enable level from the previous cycle, so it can classify both the ordinary chip-select commands and the clock-enable transitions that put the device to sleep or wake it. Each result is registered. The block reports a command code, the bank, the row, column or opcode field, and one flag that means all banks for a precharge and auto-precharge for a read or write.

Alongside the decode, the block follows the device through three power states: active, power-down and self-refresh. It shows when on-die termination cannot be used and when no refresh is taking place. It also counts down each burst so it can catch a read or write that would cut the running burst short. Any command it does not recognise, and any burst that is cut short, sets a sticky error flag. Only a reinitialise pulse clears that flag. A verification environment or an on-chip bus checker uses the block as a passive protocol monitor.

Top module: `ddr2_cmd_monitor`

## Requirements
- R1: After reset the block reports command code 0 (none), power state 0 (active), bank 0, address 0, and all of `cmd_flag`, `odt_off`, `no_refresh`, `illegal` and `burst_cut` low.
- R2: With clock enable high in the previous and current cycle, the code takes effect at the sampling edge as follows. `cs_n` high gives 1 (deselect) whatever the other pins are. With `cs_n` low, RAS/CAS/WE = 111 gives 2 (no-op), 000 gives 3 (mode register set), 001 gives 4 (refresh), 011 gives 6 (activate), 010 gives 5 (precharge), 100 gives 7 (write) and 101 gives 8 (read).
- R3: For mode register set, the bank output carries `ba` and the address output carries the full opcode. Activate carries `ba` and the full row. Read and write carry `ba`, the column with bit AP_BIT forced to 0, and `cmd_flag` equal to `addr[AP_BIT]`, which means auto-precharge. Every other command reports bank 0, address 0 and flag 0.
- R4: For precharge with `addr[AP_BIT]` low, the block reports one bank (bank = `ba`, flag 0). With it high, it reports all banks (flag 1, bank 0, `ba` ignored).
- R5: Clock enable high then low, with `cs_n` low and RAS/CAS/WE = 001, gives code 9 (self-refresh entry). The power state becomes 2 (self-refresh), and `odt_off` stays high for as long as that state lasts.
- R6: Clock enable low then high gives code 10 (self-refresh exit) when the block is in self-refresh, and code 12 (power-down exit) otherwise. All other control pins are ignored in that cycle. The power state returns to 0.
- R7: Clock enable high then low, with `cs_n` high or a no-op pattern, gives code 11 (power-down entry). The power state becomes 1, and `no_refresh` stays high for as long as that state lasts.
- R8: While clock enable is low in both cycles, the code is 0. A `cs_n`-low cycle in that period sets `illegal`.
- R9: Any other pattern gives code 13 (illegal) and sets `illegal`. This covers RAS/CAS/WE = 110 with `cs_n` low and both clock-enable levels high, and a high-to-low clock enable with any pattern other than the two entries.
- R10: A read or write that arrives while an earlier burst still has cycles left pulses `burst_cut` and sets `illegal`. A burst lasts 2 cycles when `bl_long` = 0 (length 4) and 4 cycles when `bl_long` = 1 (length 8).
- R11: `illegal` stays set until `reinit` is sampled high, and that clears it. `reinit` takes priority over a new error in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples |
| rst_n | input | 1 | Asynchronous active-low reset |
| reinit | input | 1 | Device reinitialised; clears the error flag |
| bl_long | input | 1 | Burst length: 0 = 4, 1 = 8 |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| addr | input | ADDR_W | Address bus |
| cmd_code | output | 4 | Decoded command code |
| cmd_bank | output | BA_W | Bank of the command |
| cmd_addr | output | ADDR_W | Row, column or opcode |
| cmd_flag | output | 1 | All-banks / auto-precharge |
| pwr_state | output | 2 | 0 active, 1 power-down, 2 self-refresh |
| odt_off | output | 1 | Termination unavailable (self-refresh) |
| no_refresh | output | 1 | In power-down, no refresh taking place |
| illegal | output | 1 | Sticky error flag |
| burst_cut | output | 1 | Burst interrupted this cycle |

## Verification
The bench builds the block with its default parameters: a 2-bit bank, a 13-bit address with the precharge/auto-precharge bit at position 10, and a longest burst of 8. With these values the bench can reach all four banks, see the address bit that is forced to zero, and run both burst lengths by changing `bl_long` at run time. It can therefore show a length-8 burst caught at its third cycle, and a length-4 burst that is accepted when the next command comes two cycles later.

// File: rtl/ddr2_mon_pkg.sv
package ddr2_mon_pkg;

  typedef enum logic [3:0] {
    CMD_NONE  = 4'd0,
    CMD_DESEL = 4'd1,
    CMD_NOP   = 4'd2,
    CMD_MRS   = 4'd3,
    CMD_REF   = 4'd4,
    CMD_PRE   = 4'd5,
    CMD_ACT   = 4'd6,
    CMD_WR    = 4'd7,
    CMD_RD    = 4'd8,
    CMD_SRE   = 4'd9,
    CMD_SRX   = 4'd10,
    CMD_PDE   = 4'd11,
    CMD_PDX   = 4'd12,
    CMD_BAD   = 4'd13
  } cmd_e;

  typedef enum logic [1:0] {
    PS_ACTIVE = 2'd0,
    PS_PDOWN  = 2'd1,
    PS_SREF   = 2'd2
  } pstate_e;

endpackage

// File: rtl/ddr2_cmd_classify.sv
module ddr2_cmd_classify
  import ddr2_mon_pkg::*;
(
  input  logic cke_prev,
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic in_sref,
  output cmd_e code,
  output logic bad
);

  logic [2:0] rcw;
  assign rcw = {ras_n, cas_n, we_n};

  always_comb begin
    code = CMD_NONE;
    bad  = 1'b0;
    case ({cke_prev, cke})
      2'b11: begin
        if (cs_n) begin
          code = CMD_DESEL;
        end else begin
          case (rcw)
            3'b000:  code = CMD_MRS;
            3'b001:  code = CMD_REF;
            3'b010:  code = CMD_PRE;
            3'b011:  code = CMD_ACT;
            3'b100:  code = CMD_WR;
            3'b101:  code = CMD_RD;
            3'b111:  code = CMD_NOP;
            default: begin
              code = CMD_BAD;
              bad  = 1'b1;
            end
          endcase
        end
      end
      2'b10: begin
        if (cs_n || rcw == 3'b111) begin
          code = CMD_PDE;
        end else if (rcw == 3'b001) begin
          code = CMD_SRE;
        end else begin
          code = CMD_BAD;
          bad  = 1'b1;
        end
      end
      2'b01: code = in_sref ? CMD_SRX : CMD_PDX;
      default: bad = ~cs_n;
    endcase
  end

endmodule

// File: rtl/ddr2_pwr_track.sv
module ddr2_pwr_track
  import ddr2_mon_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  cmd_e    code,
  output pstate_e state
);

  pstate_e state_d;

  always_comb begin
    state_d = state;
    case (code)
      CMD_SRE:          state_d = PS_SREF;
      CMD_PDE:          state_d = PS_PDOWN;
      CMD_SRX, CMD_PDX: state_d = PS_ACTIVE;
      default:          state_d = state;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PS_ACTIVE;
    else        state <= state_d;
  end

endmodule

// File: rtl/ddr2_burst_guard.sv
module ddr2_burst_guard #(
  parameter int MAX_BL = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic is_rw,
  input  logic bl_long,
  output logic cut
);

  localparam int CNT_W = (MAX_BL/2 > 1) ? $clog2(MAX_BL/2) : 1;
  localparam logic [CNT_W-1:0] LOAD_LONG  = CNT_W'(MAX_BL/2 - 1);
  localparam logic [CNT_W-1:0] LOAD_SHORT = CNT_W'(MAX_BL/4 - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy;

  assign busy = (cnt_q != '0);
  assign cut  = is_rw & busy;

  always_comb begin
    cnt_d = cnt_q;
    if (is_rw)     cnt_d = bl_long ? LOAD_LONG : LOAD_SHORT;
    else if (busy) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/ddr2_cmd_monitor.sv
module ddr2_cmd_monitor
  import ddr2_mon_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10,
  parameter int MAX_BL = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reinit,
  input  logic              bl_long,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  output logic [3:0]        cmd_code,
  output logic [BA_W-1:0]   cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_flag,
  output logic [1:0]        pwr_state,
  output logic              odt_off,
  output logic              no_refresh,
  output logic              illegal,
  output logic              burst_cut
);

  logic              cke_prev_q;
  cmd_e              code_c;
  logic              bad_c, cut_c, is_rw;
  pstate_e           state;
  logic [BA_W-1:0]   bank_d;
  logic [ADDR_W-1:0] addr_d;
  logic              flag_d, illegal_d;

  ddr2_cmd_classify u_classify (
    .cke_prev (cke_prev_q),
    .cke      (cke),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .in_sref  (state == PS_SREF),
    .code     (code_c),
    .bad      (bad_c)
  );

  ddr2_pwr_track u_pwr (
    .clk   (clk),
    .rst_n (rst_n),
    .code  (code_c),
    .state (state)
  );

  assign is_rw = (code_c == CMD_RD) || (code_c == CMD_WR);

  ddr2_burst_guard #(.MAX_BL(MAX_BL)) u_burst (
    .clk     (clk),
    .rst_n   (rst_n),
    .is_rw   (is_rw),
    .bl_long (bl_long),
    .cut     (cut_c)
  );

  always_comb begin
    bank_d = '0;
    addr_d = '0;
    flag_d = 1'b0;
    case (code_c)
      CMD_MRS, CMD_ACT: begin
        bank_d = ba;
        addr_d = addr;
      end
      CMD_PRE: begin
        flag_d = addr[AP_BIT];
        if (!addr[AP_BIT]) bank_d = ba;
      end
      CMD_RD, CMD_WR: begin
        bank_d         = ba;
        addr_d         = addr;
        addr_d[AP_BIT] = 1'b0;
        flag_d         = addr[AP_BIT];
      end
      default: ;
    endcase
    illegal_d = reinit ? 1'b0 : (illegal | bad_c | cut_c);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_prev_q <= 1'b1;
      cmd_code   <= CMD_NONE;
      cmd_bank   <= '0;
      cmd_addr   <= '0;
      cmd_flag   <= 1'b0;
      illegal    <= 1'b0;
      burst_cut  <= 1'b0;
    end else begin
      cke_prev_q <= cke;
      cmd_code   <= code_c;
      cmd_bank   <= bank_d;
      cmd_addr   <= addr_d;
      cmd_flag   <= flag_d;
      illegal    <= illegal_d;
      burst_cut  <= cut_c;
    end
  end

  assign pwr_state  = state;
  assign odt_off    = (state == PS_SREF);
  assign no_refresh = (state == PS_PDOWN);

endmodule

// File: rtl/ddr2_cmd_monitor_chk.sv
module ddr2_cmd_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reinit,
  input logic [3:0] cmd_code,
  input logic [1:0] pwr_state,
  input logic       odt_off,
  input logic       no_refresh,
  input logic       illegal,
  input logic       burst_cut
);

  // R5
  sref_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == 4'd9) |-> (pwr_state == 2'd2 && odt_off));

  // R7
  pdown_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == 4'd11) |-> (pwr_state == 2'd1 && no_refresh));

  // R6
  wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == 4'd10 || cmd_code == 4'd12) |-> (pwr_state == 2'd0));

  // R8
  asleep_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state != 2'd0) |-> (cmd_code == 4'd0 || cmd_code == 4'd9 || cmd_code == 4'd11));

  // R9
  bad_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == 4'd13) |-> (illegal || $past(reinit)));

  // R10
  cut_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_cut |-> (illegal || $past(reinit)));

  // R11
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal && !reinit) |=> illegal);

endmodule

bind ddr2_cmd_monitor ddr2_cmd_monitor_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reinit     (reinit),
  .cmd_code   (cmd_code),
  .pwr_state  (pwr_state),
  .odt_off    (odt_off),
  .no_refresh (no_refresh),
  .illegal    (illegal),
  .burst_cut  (burst_cut)
);

// File: tb/ddr2_cmd_monitor_bench.sv
module ddr2_cmd_monitor_bench;

  logic        clk = 1'b0;
  logic        rst_n, reinit, bl_long;
  logic        cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [12:0] addr;
  logic [3:0]  cmd_code;
  logic [1:0]  cmd_bank;
  logic [12:0] cmd_addr;
  logic        cmd_flag;
  logic [1:0]  pwr_state;
  logic        odt_off, no_refresh, illegal, burst_cut;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ddr2_cmd_monitor u_ddr2_cmd_monitor (
    .clk(clk), .rst_n(rst_n), .reinit(reinit), .bl_long(bl_long),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .cmd_flag(cmd_flag), .pwr_state(pwr_state),
    .odt_off(odt_off), .no_refresh(no_refresh), .illegal(illegal),
    .burst_cut(burst_cut)
  );

  // {cs,ras,cas,we, ba, addr, exp_code, exp_bank, exp_addr, exp_flag}
  localparam int NV = 11;
  localparam logic [38:0] VEC [0:NV-1] = '{
    {4'b0111, 2'd0, 13'h0000, 4'd2, 2'd0, 13'h0000, 1'b0},
    {4'b1000, 2'd3, 13'h1FFF, 4'd1, 2'd0, 13'h0000, 1'b0},
    {4'b0000, 2'd2, 13'h0432, 4'd3, 2'd2, 13'h0432, 1'b0},
    {4'b0001, 2'd1, 13'h0005, 4'd4, 2'd0, 13'h0000, 1'b0},
    {4'b0011, 2'd1, 13'h1ABC, 4'd6, 2'd1, 13'h1ABC, 1'b0},
    {4'b0010, 2'd3, 13'h0000, 4'd5, 2'd3, 13'h0000, 1'b0},
    {4'b0010, 2'd2, 13'h0400, 4'd5, 2'd0, 13'h0000, 1'b1},
    {4'b0100, 2'd1, 13'h0408, 4'd7, 2'd1, 13'h0008, 1'b1},
    {4'b0111, 2'd0, 13'h0000, 4'd2, 2'd0, 13'h0000, 1'b0},
    {4'b0101, 2'd2, 13'h0010, 4'd8, 2'd2, 13'h0010, 1'b0},
    {4'b0111, 2'd0, 13'h0000, 4'd2, 2'd0, 13'h0000, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic k, input logic [3:0] ctl,
                     input logic [1:0] b, input logic [12:0] a);
    @(negedge clk);
    cke = k;
    {cs_n, ras_n, cas_n, we_n} = ctl;
    ba = b;
    addr = a;
    @(posedge clk);
    #2;
  endtask

  task automatic do_reinit();
    @(negedge clk);
    reinit = 1'b1;
    cke = 1'b1;
    {cs_n, ras_n, cas_n, we_n} = 4'b0111;
    @(posedge clk);
    #2;
    @(negedge clk);
    reinit = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reinit = 1'b0; bl_long = 1'b0;
    cke = 1'b1; {cs_n, ras_n, cas_n, we_n} = 4'b0111; ba = '0; addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 code", cmd_code, 0);
    chk("R1 pwr", pwr_state, 0);
    chk("R1 flags", {cmd_flag, odt_off, no_refresh, illegal, burst_cut}, 0);
    chk("R1 bank/addr", {cmd_bank, cmd_addr}, 0);

    // R2 R3 R4 table walk
    for (int i = 0; i < NV; i++) begin
      cyc(1'b1, VEC[i][38:35], VEC[i][34:33], VEC[i][32:20]);
      chk("R2 code", cmd_code, int'(VEC[i][19:16]));
      chk("R3 bank", cmd_bank, int'(VEC[i][15:14]));
      chk("R3 addr", cmd_addr, int'(VEC[i][13:1]));
      chk("R4 flag", cmd_flag, int'(VEC[i][0]));
      chk("R2 no error", illegal, 0);
    end

    // R9 unsupported pattern, R11 sticky then cleared
    cyc(1'b1, 4'b0110, 2'd0, 13'h0);
    chk("R9 code", cmd_code, 13);
    chk("R9 illegal", illegal, 1);
    cyc(1'b1, 4'b0111, 2'd0, 13'h0);
    cyc(1'b1, 4'b1111, 2'd0, 13'h0);
    chk("R11 sticky", illegal, 1);
    do_reinit();
    chk("R11 cleared", illegal, 0);

    // R10 burst of 4 cut on next cycle
    cyc(1'b1, 4'b0101, 2'd0, 13'h0);
    cyc(1'b1, 4'b0100, 2'd0, 13'h0);
    chk("R10 bl4 cut", burst_cut, 1);
    chk("R10 bl4 illegal", illegal, 1);
    cyc(1'b1, 4'b0111, 2'd0, 13'h0);
    chk("R10 cut pulse", burst_cut, 0);
    do_reinit();
    cyc(1'b1, 4'b0111, 2'd0, 13'h0);
    // R10 burst of 4 followed two cycles later: legal
    cyc(1'b1, 4'b0101, 2'd0, 13'h0);
    cyc(1'b1, 4'b0111, 2'd0, 13'h0);
    cyc(1'b1, 4'b0101, 2'd0, 13'h0);
    chk("R10 bl4 gap ok", burst_cut, 0);
    chk("R10 bl4 gap no err", illegal, 0);
    cyc(1'b1, 4'b0111, 2'd0, 13'h0);
    // R10 burst of 8 cut at third cycle
    bl_long = 1'b1;
    cyc(1'b1, 4'b0101, 2'd0, 13'h0);
    cyc(1'b1, 4'b0111, 2'd0, 13'h0);
    cyc(1'b1, 4'b0100, 2'd0, 13'h0);
    chk("R10 bl8 cut", burst_cut, 1);
    repeat (4) cyc(1'b1, 4'b0111, 2'd0, 13'h0);
    do_reinit();
    bl_long = 1'b0;

    // R5 self-refresh entry
    cyc(1'b0, 4'b0001, 2'd0, 13'h0);
    chk("R5 code", cmd_code, 9);
    chk("R5 pwr", pwr_state, 2);
    chk("R5 odt_off", odt_off, 1);
    // R8 held low
    cyc(1'b0, 4'b1111, 2'd0, 13'h0);
    chk("R8 code none", cmd_code, 0);
    chk("R5 odt held", odt_off, 1);
    // R6 exit ignores other pins
    cyc(1'b1, 4'b0000, 2'd3, 13'h1FFF);
    chk("R6 srx code", cmd_code, 10);
    chk("R6 srx pwr", pwr_state, 0);
    chk("R6 odt clear", odt_off, 0);
    chk("R6 no error", illegal, 0);

    // R7 power-down entry
    cyc(1'b1, 4'b0111, 2'd0, 13'h0);
    cyc(1'b0, 4'b1000, 2'd0, 13'h0);
    chk("R7 code", cmd_code, 11);
    chk("R7 pwr", pwr_state, 1);
    chk("R7 no_refresh", no_refresh, 1);
    // R8 cs low while held low
    cyc(1'b0, 4'b0011, 2'd0, 13'h0);
    chk("R8 code", cmd_code, 0);
    chk("R8 illegal", illegal, 1);
    cyc(1'b1, 4'b0010, 2'd0, 13'h0);
    chk("R6 pdx code", cmd_code, 12);
    chk("R6 pdx pwr", pwr_state, 0);
    chk("R7 no_refresh clear", no_refresh, 0);
    do_reinit();

    // R9 clock-enable drop with an activate pattern
    cyc(1'b0, 4'b0011, 2'd0, 13'h0);
    chk("R9 drop code", cmd_code, 13);
    chk("R9 drop illegal", illegal, 1);
    chk("R9 drop pwr", pwr_state, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule